// File: doc/BRIEF.md
# Reuse Pattern Predictor

This block sits beside the tag array of a set-associative private cache and learns, per line, whether a line is worth handing to a peer cache once it is evicted. Every access event is sorted into one of two kinds. A short-interval access touches the same way that was most recently touched in its set. A long-interval access finds that another way of the set was touched in between. Each line counts both kinds in small saturating counters. The two counters together form a 4-bit pattern index.

A 16-entry table of 2-bit saturating counters learns which patterns tend to be reused. A line that a peer processor wrote into this cache raises its pattern's counter the first time it is hit. If such a line leaves the cache without ever being hit, the counter drops. A peer can also report, by pattern index, that a line it received was reused. On each eviction the block reports one registered cycle later whether the leaving line's pattern currently predicts low reusability.

The cache controller drives fill and hit events with set, way and installing owner. It drives eviction events with set and way, and forwards reuse reports from peers. Tag matching, data storage and coherence are handled elsewhere.

Top module: `reuse_pattern_predictor`

## Requirements
- R1: After reset every per-line counter, reused flag, owner field, set MRU field and pattern counter is zero, and `pred_valid` and `pred_low` are 0.
- R2: A hit (`acc_valid`=1, `acc_hit`=1) whose way equals the set's most recently accessed way increments that line's short-interval counter; otherwise it increments the long-interval counter. Every fill or hit makes its way the set's most recently accessed way.
- R3: Both per-line counters saturate at 3.
- R4: A fill (`acc_valid`=1, `acc_hit`=0) clears both counters and the reused flag of the way and records `acc_owner` as the line's owner.
- R5: A line's pattern index is {long counter, short counter}: the long count in bits 3:2 and the short count in bits 1:0.
- R6: A hit on a line whose owner differs from LOCAL_ID and whose reused flag is clear sets the flag. It also increments the pattern counter selected by the line's index before that hit's count update, saturating at 3. Later hits on that line and hits on local lines leave the table unchanged.
- R7: Evicting a line whose owner differs from LOCAL_ID and whose reused flag is clear decrements its pattern counter, saturating at 0. Other evictions leave the table unchanged.
- R8: A reuse report (`rn_valid`=1) increments the pattern counter at `rn_pattern`, saturating at 3. All increments and decrements that reach one entry in the same cycle are summed before saturation.
- R9: The cycle after `ev_valid`, `pred_valid` is 1 and `pred_pattern` shows the evicted line's index. `pred_low` is 1 exactly when that pattern's counter, taken before that cycle's updates, is below 2. In every other cycle `pred_valid` and `pred_low` are 0.
- R10: An eviction reads the line state as it was before any access in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event strobe |
| acc_hit | input | 1 | 1 = hit on a resident line, 0 = fill of a new line |
| acc_set | input | SET_W | Set of the access |
| acc_way | input | WAY_W | Way of the access |
| acc_owner | input | OWNER_W | Processor that installed the line (used on fill) |
| ev_valid | input | 1 | Eviction strobe |
| ev_set | input | SET_W | Set of the evicted line |
| ev_way | input | WAY_W | Way of the evicted line |
| rn_valid | input | 1 | Peer reuse report strobe |
| rn_pattern | input | 4 | Pattern index of the reused line |
| pred_valid | output | 1 | Prediction present (one cycle after eviction) |
| pred_low | output | 1 | Evicted line predicted to have low reusability |
| pred_pattern | output | 4 | Pattern index of the evicted line |

## Verification
The checker watches the prediction handshake on every cycle. It confirms that each eviction yields exactly one prediction in the next cycle, that no prediction appears without an eviction, and that the low flag never shows while the result is invalid. It also checks that the pattern table holds still in any cycle without a hit, eviction or reuse report. The short and long classification, counter saturation, first-hit learning, the decrement for unused lines and the merging of same-cycle updates are visible only through the values reported on eviction. The bench therefore compares each prediction against an arithmetic model over a small cache: an exhaustive eviction sweep after reset, a directed saturation run, and a long mixed stream.

// File: rtl/rpp_pkg.sv
package rpp_pkg;
   localparam int CNT_W   = 2;
   localparam int PIDX_W  = 2 * CNT_W;
   localparam int PAT_N   = 1 << PIDX_W;
   localparam int PCNT_W  = 2;

   function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
      return (&v) ? v : v + 1'b1;
   endfunction
endpackage

// File: rtl/rpp_line_store.sv
module rpp_line_store
   import rpp_pkg::*;
#(
   parameter int SETS = 16,
   parameter int WAYS = 4,
   parameter int OWNER_W = 2,
   parameter logic [OWNER_W-1:0] LOCAL_ID = '0,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_hit,
   input  logic [SET_W-1:0]   acc_set,
   input  logic [WAY_W-1:0]   acc_way,
   input  logic [OWNER_W-1:0] acc_owner,
   input  logic [SET_W-1:0]   ev_set,
   input  logic [WAY_W-1:0]   ev_way,
   output logic [PIDX_W-1:0]  acc_pidx,
   output logic               acc_first_reuse,
   output logic [PIDX_W-1:0]  ev_pidx,
   output logic               ev_unused_foreign
);
   localparam int LINES = SETS * WAYS;
   localparam int LI_W  = SET_W + WAY_W;

   logic [CNT_W-1:0]   short_q [LINES];
   logic [CNT_W-1:0]   long_q  [LINES];
   logic               used_q  [LINES];
   logic [OWNER_W-1:0] own_q   [LINES];
   logic [WAY_W-1:0]   mru_q   [SETS];

   logic [LI_W-1:0] acc_li, ev_li;
   logic            same_way;

   assign acc_li   = {acc_set, acc_way};
   assign ev_li    = {ev_set, ev_way};
   assign same_way = (mru_q[acc_set] == acc_way);

   assign acc_pidx        = {long_q[acc_li], short_q[acc_li]};
   assign acc_first_reuse = acc_hit && (own_q[acc_li] != LOCAL_ID) && !used_q[acc_li];
   assign ev_pidx         = {long_q[ev_li], short_q[ev_li]};
   assign ev_unused_foreign = (own_q[ev_li] != LOCAL_ID) && !used_q[ev_li];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            short_q[i] <= '0;
            long_q[i]  <= '0;
            used_q[i]  <= 1'b0;
            own_q[i]   <= '0;
         end
         for (int s = 0; s < SETS; s++) mru_q[s] <= '0;
      end else if (acc_valid) begin
         if (!acc_hit) begin
            short_q[acc_li] <= '0;
            long_q[acc_li]  <= '0;
            used_q[acc_li]  <= 1'b0;
            own_q[acc_li]   <= acc_owner;
         end else begin
            if (same_way) short_q[acc_li] <= sat_inc(short_q[acc_li]);
            else          long_q[acc_li]  <= sat_inc(long_q[acc_li]);
            if (own_q[acc_li] != LOCAL_ID) used_q[acc_li] <= 1'b1;
         end
         mru_q[acc_set] <= acc_way;
      end
   end
endmodule

// File: rtl/rpp_pattern_table.sv
module rpp_pattern_table
   import rpp_pkg::*;
#(
   parameter int LOW_THRESH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    inc_a_v,
   input  logic [PIDX_W-1:0]       inc_a_idx,
   input  logic                    inc_b_v,
   input  logic [PIDX_W-1:0]       inc_b_idx,
   input  logic                    dec_v,
   input  logic [PIDX_W-1:0]       dec_idx,
   input  logic [PIDX_W-1:0]       rd_idx,
   output logic                    rd_low,
   output logic [PAT_N*PCNT_W-1:0] cnt_flat
);
   localparam logic signed [4:0] CMAX = 5'sd3;

   for (genvar i = 0; i < PAT_N; i++) begin : g_ent
      logic [PCNT_W-1:0] cnt_q;
      logic [3:0]        up, dn;
      logic signed [4:0] nxt;

      always_comb begin
         up  = 4'(inc_a_v && (inc_a_idx == PIDX_W'(i)))
             + 4'(inc_b_v && (inc_b_idx == PIDX_W'(i)));
         dn  = 4'(dec_v && (dec_idx == PIDX_W'(i)));
         nxt = $signed({1'b0, 4'(cnt_q)}) + $signed({1'b0, up}) - $signed({1'b0, dn});
      end

      always_ff @(posedge clk) begin
         if (!rst_n)              cnt_q <= '0;
         else if (nxt < 5'sd0)    cnt_q <= '0;
         else if (nxt > CMAX)     cnt_q <= PCNT_W'(3);
         else                     cnt_q <= nxt[PCNT_W-1:0];
      end

      assign cnt_flat[i*PCNT_W +: PCNT_W] = cnt_q;
   end

   logic [PCNT_W-1:0] rd_cnt;
   assign rd_cnt = cnt_flat[rd_idx*PCNT_W +: PCNT_W];

   if (LOW_THRESH == 0) begin : g_never_low
      assign rd_low = 1'b0;
   end else if (LOW_THRESH > 3) begin : g_always_low
      assign rd_low = 1'b1;
   end else begin : g_cmp_low
      assign rd_low = (rd_cnt < PCNT_W'(LOW_THRESH));
   end
endmodule

// File: rtl/reuse_pattern_predictor.sv
module reuse_pattern_predictor
   import rpp_pkg::*;
#(
   parameter int SETS = 16,
   parameter int WAYS = 4,
   parameter int OWNER_W = 2,
   parameter logic [OWNER_W-1:0] LOCAL_ID = '0,
   parameter int LOW_THRESH = 2,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_hit,
   input  logic [SET_W-1:0]   acc_set,
   input  logic [WAY_W-1:0]   acc_way,
   input  logic [OWNER_W-1:0] acc_owner,
   input  logic               ev_valid,
   input  logic [SET_W-1:0]   ev_set,
   input  logic [WAY_W-1:0]   ev_way,
   input  logic               rn_valid,
   input  logic [PIDX_W-1:0]  rn_pattern,
   output logic               pred_valid,
   output logic               pred_low,
   output logic [PIDX_W-1:0]  pred_pattern
);
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (OWNER_W < 1) begin : g_bad_owner
      $error("OWNER_W must be at least 1");
   end

   logic [PIDX_W-1:0]       acc_pidx, ev_pidx;
   logic                    acc_first_reuse, ev_unused_foreign, rd_low;
   logic [PAT_N*PCNT_W-1:0] pat_flat;

   rpp_line_store #(
      .SETS(SETS), .WAYS(WAYS), .OWNER_W(OWNER_W), .LOCAL_ID(LOCAL_ID)
   ) u_lines (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_set(acc_set),
      .acc_way(acc_way), .acc_owner(acc_owner),
      .ev_set(ev_set), .ev_way(ev_way),
      .acc_pidx(acc_pidx), .acc_first_reuse(acc_first_reuse),
      .ev_pidx(ev_pidx), .ev_unused_foreign(ev_unused_foreign)
   );

   rpp_pattern_table #(.LOW_THRESH(LOW_THRESH)) u_table (
      .clk(clk), .rst_n(rst_n),
      .inc_a_v(acc_valid && acc_first_reuse), .inc_a_idx(acc_pidx),
      .inc_b_v(rn_valid), .inc_b_idx(rn_pattern),
      .dec_v(ev_valid && ev_unused_foreign), .dec_idx(ev_pidx),
      .rd_idx(ev_pidx), .rd_low(rd_low), .cnt_flat(pat_flat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_valid   <= 1'b0;
         pred_low     <= 1'b0;
         pred_pattern <= '0;
      end else begin
         pred_valid   <= ev_valid;
         pred_low     <= ev_valid && rd_low;
         pred_pattern <= ev_valid ? ev_pidx : '0;
      end
   end
endmodule

// File: rtl/rpp_checker.sv
module rpp_checker #(
   parameter int TW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          acc_valid,
   input logic          ev_valid,
   input logic          rn_valid,
   input logic          pred_valid,
   input logic          pred_low,
   input logic [TW-1:0] pat_flat
);
   // R9: every eviction produces a prediction in the next cycle
   p_evict_gives_pred_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> pred_valid);
   // R9: no prediction without an eviction one cycle earlier
   p_idle_no_pred_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> !pred_valid);
   // R9: low flag only alongside a valid prediction
   p_low_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pred_low |-> pred_valid);
   // R8: the pattern table moves only on hits, evictions or reuse reports
   p_table_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid && !ev_valid && !rn_valid) |=> $stable(pat_flat));
endmodule

bind reuse_pattern_predictor rpp_checker #(.TW(rpp_pkg::PAT_N * rpp_pkg::PCNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .ev_valid(ev_valid),
   .rn_valid(rn_valid), .pred_valid(pred_valid), .pred_low(pred_low),
   .pat_flat(pat_flat)
);

// File: tb/reuse_pattern_predictor_bench.sv
module reuse_pattern_predictor_bench;
   localparam int NS = 4;
   localparam int NW = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 0, acc_hit = 0, ev_valid = 0, rn_valid = 0;
   logic [1:0] acc_set = 0, acc_way = 0, acc_owner = 0, ev_set = 0, ev_way = 0;
   logic [3:0] rn_pattern = 0;
   logic       pred_valid, pred_low;
   logic [3:0] pred_pattern;

   always #2 clk = ~clk;

   reuse_pattern_predictor #(.SETS(NS), .WAYS(NW), .OWNER_W(2), .LOCAL_ID(2'd0))
   u_reuse_pattern_predictor (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
      .acc_set(acc_set), .acc_way(acc_way), .acc_owner(acc_owner),
      .ev_valid(ev_valid), .ev_set(ev_set), .ev_way(ev_way),
      .rn_valid(rn_valid), .rn_pattern(rn_pattern),
      .pred_valid(pred_valid), .pred_low(pred_low), .pred_pattern(pred_pattern)
   );

   int vectors = 0, fails = 0;
   bit done = 0;
   string tag = "R1";

   int m_sc [16], m_lc [16], m_re [16], m_ow [16], m_mru [4], m_pat [16];
   bit exp_valid = 0, exp_low = 0;
   int exp_pat = 0;

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_outputs();
      chk("R9 valid", int'(pred_valid), int'(exp_valid));
      if (exp_valid) begin
         chk({tag, " pattern R5"}, int'(pred_pattern), exp_pat);
         chk({tag, " low R6,R7,R8,R9"}, int'(pred_low), int'(exp_low));
      end else begin
         chk("R9 low idle", int'(pred_low), 0);
      end
   endtask

   // one cycle: drive, update the model, clock, then compare
   task automatic step(input bit av, input bit ah, input int s, input int w, input int ow,
                       input bit ev, input int es, input int ew, input bit rn, input int rp);
      int d [16];
      int ali, eli, pi;
      acc_valid = av; acc_hit = ah; acc_set = 2'(s); acc_way = 2'(w); acc_owner = 2'(ow);
      ev_valid = ev; ev_set = 2'(es); ev_way = 2'(ew);
      rn_valid = rn; rn_pattern = 4'(rp);
      for (int i = 0; i < 16; i++) d[i] = 0;
      ali = s * NW + w;
      eli = es * NW + ew;
      // R10: eviction sees pre-access state
      exp_valid = ev;
      exp_pat = m_lc[eli] * 4 + m_sc[eli];
      exp_low = ev && (m_pat[exp_pat] < 2);
      if (ev && m_ow[eli] != 0 && m_re[eli] == 0) d[exp_pat] -= 1;
      if (rn) d[rp] += 1;
      if (av) begin
         if (!ah) begin
            m_sc[ali] = 0; m_lc[ali] = 0; m_re[ali] = 0; m_ow[ali] = ow;
         end else begin
            pi = m_lc[ali] * 4 + m_sc[ali];
            if (m_ow[ali] != 0 && m_re[ali] == 0) begin
               d[pi] += 1;
               m_re[ali] = 1;
            end
            if (m_mru[s] == w) m_sc[ali] = (m_sc[ali] < 3) ? m_sc[ali] + 1 : 3;
            else               m_lc[ali] = (m_lc[ali] < 3) ? m_lc[ali] + 1 : 3;
         end
         m_mru[s] = w;
      end
      for (int i = 0; i < 16; i++) begin
         m_pat[i] += d[i];
         if (m_pat[i] < 0) m_pat[i] = 0;
         if (m_pat[i] > 3) m_pat[i] = 3;
      end
      @(posedge clk);
      @(negedge clk);
      check_outputs();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_sc[i] = 0; m_lc[i] = 0; m_re[i] = 0; m_ow[i] = 0; m_pat[i] = 0;
      end
      for (int i = 0; i < 4; i++) m_mru[i] = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 pred_valid after reset", int'(pred_valid), 0);
      chk("R1 pred_low after reset", int'(pred_low), 0);
      // R1: exhaustive eviction sweep of every line straight after reset
      tag = "R1";
      for (int l = 0; l < NS * NW; l++) step(0, 0, 0, 0, 0, 1, l / NW, l % NW, 0, 0);
      // R3,R4,R2: fill, saturate the short counter, then the long counter
      tag = "R3";
      step(1, 0, 1, 2, 1, 0, 0, 0, 0, 0);
      for (int k = 0; k < 5; k++) step(1, 1, 1, 2, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 1, 2, 0, 0);
      for (int k = 0; k < 5; k++) begin
         step(1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
         step(1, 1, 1, 2, 0, 0, 0, 0, 0, 0);
      end
      step(0, 0, 0, 0, 0, 1, 1, 2, 0, 0);
      // R8: reuse reports saturate one entry, then an eviction reads it
      tag = "R8";
      for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 1, 15);
      step(0, 0, 0, 0, 0, 1, 1, 2, 1, 15);
      // R6,R7,R10: mixed stream over the small cache
      tag = "R2,R4,R6,R7,R10";
      for (int k = 0; k < 6000; k++) begin
         automatic int r = int'($urandom);
         step((r & 3) != 0, ((r >> 2) & 3) != 0, (r >> 4) & 3, (r >> 6) & 3, (r >> 8) & 3,
              ((r >> 10) & 3) == 0, (r >> 12) & 3, (r >> 14) & 3,
              ((r >> 16) & 7) == 0, (r >> 19) & 15);
      end
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      vectors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end
endmodule